// File: doc/BRIEF.md
# Internal Data Memory Access Router

This block steers the data accesses of a small 8-bit controller core to on-chip storage. It serves two request ports, one for direct addressing and one for indirect addressing. The storage behind them is a 256-byte RAM and a 128-byte window of special-function registers that live in peripherals outside the block. The top half of the address range is decoded by addressing mode. A direct access at 128..255 leaves the block as a strobe on the special-function bus. An indirect access at the same addresses lands in upper RAM. The bottom half is one shared lower RAM for both ports.

Beside the two ports, the block computes the RAM address of the working registers R0..R7 from the two bank-select bits of the status word. It also owns the stack pointer. A push or pop borrows the indirect RAM port for one cycle.

Every read is synchronous: data asked for in one cycle appears on the matching read-data output in the next cycle. Special-function read data follows the same timing, because it is taken from the peripheral bus one cycle after the strobe.

Top module: `idata_router`

## Requirements
- R1: A direct or indirect access at addresses 0x00..0x7F reaches the same lower RAM byte, so a byte written through one port reads back through the other.
- R2: An indirect access at 0x80..0xFF reads and writes upper RAM.
- R3: A direct access at 0x80..0xFF raises `sfr_req_o` in the same cycle. That cycle also carries `sfr_addr_o` = address bits [6:0], `sfr_we_o` and `sfr_wdata_o`. RAM is left unchanged. `sfr_req_o` is low for every other access.
- R4: Read data appears on `dir_rdata_o`, `ind_rdata_o` or `stk_rdata_o` in the cycle after the request. A direct special-function read returns the `sfr_rdata_i` value present in that following cycle.
- R5: `reg_addr_o` equals `bank_sel_i`*8 + `reg_idx_i`, and its bits [7:5] are zero.
- R6: After reset, `sp_o` is 0x07.
- R7: A push first increments the stack pointer, then writes `stk_wdata_i` to RAM at the new pointer value.
- R8: A pop reads RAM at the current pointer, returns that byte on `stk_rdata_o` in the next cycle, and decrements the pointer.
- R9: The stack pointer wraps modulo 256 in both directions: a pop at 0x00 gives 0xFF, and a push at 0xFF writes address 0x00.
- R10: When `push_i` and `pop_i` are both high, only the push takes effect.
- R11: A push or pop owns the indirect RAM port for its cycle. A simultaneous indirect request is dropped and writes nothing.
- R12: When both ports write the same lower RAM byte in one cycle, the indirect port's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_req_i | input | 1 | Direct access request |
| dir_we_i | input | 1 | Direct access is a write |
| dir_addr_i | input | 8 | Direct address |
| dir_wdata_i | input | 8 | Direct write data |
| dir_rdata_o | output | 8 | Direct read data, one cycle after the request |
| ind_req_i | input | 1 | Indirect access request |
| ind_we_i | input | 1 | Indirect access is a write |
| ind_addr_i | input | 8 | Indirect address |
| ind_wdata_i | input | 8 | Indirect write data |
| ind_rdata_o | output | 8 | Indirect read data, one cycle after the request |
| bank_sel_i | input | 2 | Register bank select from the status word |
| reg_idx_i | input | 3 | Working register number 0..7 |
| reg_addr_o | output | 8 | RAM address of the selected working register |
| push_i | input | 1 | Stack push |
| pop_i | input | 1 | Stack pop |
| stk_wdata_i | input | 8 | Data to push |
| stk_rdata_o | output | 8 | Popped data, one cycle after the pop |
| sp_o | output | 8 | Stack pointer |
| sfr_req_o | output | 1 | Special-function register strobe |
| sfr_we_o | output | 1 | Special-function access is a write |
| sfr_addr_o | output | 7 | Special-function register offset |
| sfr_wdata_o | output | 8 | Special-function write data |
| sfr_rdata_i | input | 8 | Special-function read data, valid the cycle after the strobe |

## Verification
Two kinds of operation compete for a RAM port in the same cycle. In the first, a stack push collides with an indirect write. In the second, both ports write the same lower byte at once. The bench drives each pair on one clock edge. It then reads the contested locations back through a port that is idle at that point. The dropped indirect write must have left its target unchanged, the pushed byte must sit at the new pointer, and a same-byte collision must hold the indirect data. A third case sends a direct and an indirect access to one upper address: the special-function model and upper RAM must each keep their own value.

// File: rtl/idr_pkg.sv
package idr_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned SFR_AW = ADDR_W - 1;
  localparam int unsigned BANK_W = 2;
  localparam int unsigned RIDX_W = 3;

  typedef struct packed {
    logic              en;
    logic              we;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } mem_req_t;
endpackage

// File: rtl/idr_decode.sv
module idr_decode
  import idr_pkg::*;
(
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output mem_req_t          ram_o,
  output logic              sfr_req_o,
  output logic              sfr_we_o,
  output logic [SFR_AW-1:0] sfr_addr_o,
  output logic [DATA_W-1:0] sfr_wdata_o
);
  logic upper;
  assign upper       = addr_i[ADDR_W-1];
  assign sfr_req_o   = req_i & upper;
  assign sfr_we_o    = we_i;
  assign sfr_addr_o  = addr_i[SFR_AW-1:0];
  assign sfr_wdata_o = wdata_i;

  always_comb begin
    ram_o.en    = req_i & ~upper;
    ram_o.we    = we_i;
    ram_o.addr  = addr_i;
    ram_o.wdata = wdata_i;
  end
endmodule

// File: rtl/idr_stack.sv
module idr_stack
  import idr_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SP_RESET = 8'h07
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] wdata_i,
  output mem_req_t          ram_o,
  output logic [ADDR_W-1:0] sp_o
);
  logic [ADDR_W-1:0] sp_q, sp_inc, sp_dec;
  assign sp_inc = sp_q + 1'b1;
  assign sp_dec = sp_q - 1'b1;
  assign sp_o   = sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sp_q <= SP_RESET;
    else if (push_i)  sp_q <= sp_inc;
    else if (pop_i)   sp_q <= sp_dec;
  end

  always_comb begin
    ram_o.en    = push_i | pop_i;
    ram_o.we    = push_i;
    ram_o.addr  = push_i ? sp_inc : sp_q;
    ram_o.wdata = wdata_i;
  end
endmodule

// File: rtl/idr_ram.sv
module idr_ram
  import idr_pkg::*;
#(
  parameter int unsigned DEPTH = 2 ** ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  mem_req_t          a_i,
  input  mem_req_t          b_i,
  output logic [DATA_W-1:0] a_rdata_o,
  output logic [DATA_W-1:0] b_rdata_o
);
  localparam int unsigned IW = $clog2(DEPTH);
  logic [DATA_W-1:0] mem [DEPTH];

  // port b written last: it wins a same-address collision
  always_ff @(posedge clk_i) begin
    if (a_i.en && a_i.we) mem[a_i.addr[IW-1:0]] <= a_i.wdata;
    if (b_i.en && b_i.we) mem[b_i.addr[IW-1:0]] <= b_i.wdata;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_rdata_o <= '0;
      b_rdata_o <= '0;
    end else begin
      if (a_i.en && !a_i.we) a_rdata_o <= mem[a_i.addr[IW-1:0]];
      if (b_i.en && !b_i.we) b_rdata_o <= mem[b_i.addr[IW-1:0]];
    end
  end
endmodule

// File: rtl/idata_router.sv
module idata_router
  import idr_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SP_RESET = 8'h07
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_req_i,
  input  logic              dir_we_i,
  input  logic [ADDR_W-1:0] dir_addr_i,
  input  logic [DATA_W-1:0] dir_wdata_i,
  output logic [DATA_W-1:0] dir_rdata_o,
  input  logic              ind_req_i,
  input  logic              ind_we_i,
  input  logic [ADDR_W-1:0] ind_addr_i,
  input  logic [DATA_W-1:0] ind_wdata_i,
  output logic [DATA_W-1:0] ind_rdata_o,
  input  logic [BANK_W-1:0] bank_sel_i,
  input  logic [RIDX_W-1:0] reg_idx_i,
  output logic [ADDR_W-1:0] reg_addr_o,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] stk_wdata_i,
  output logic [DATA_W-1:0] stk_rdata_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic              sfr_req_o,
  output logic              sfr_we_o,
  output logic [SFR_AW-1:0] sfr_addr_o,
  output logic [DATA_W-1:0] sfr_wdata_o,
  input  logic [DATA_W-1:0] sfr_rdata_i
);
  localparam int unsigned PAD_W = ADDR_W - BANK_W - RIDX_W;

  mem_req_t dir_ram, stk_ram, port_b;
  logic [DATA_W-1:0] ram_a_rdata, ram_b_rdata;
  logic dir_sfr_rd_q;

  assign reg_addr_o = {{PAD_W{1'b0}}, bank_sel_i, reg_idx_i};

  idr_decode u_decode (
    .req_i      (dir_req_i),
    .we_i       (dir_we_i),
    .addr_i     (dir_addr_i),
    .wdata_i    (dir_wdata_i),
    .ram_o      (dir_ram),
    .sfr_req_o  (sfr_req_o),
    .sfr_we_o   (sfr_we_o),
    .sfr_addr_o (sfr_addr_o),
    .sfr_wdata_o(sfr_wdata_o)
  );

  idr_stack #(.SP_RESET(SP_RESET)) u_stack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push_i),
    .pop_i  (pop_i),
    .wdata_i(stk_wdata_i),
    .ram_o  (stk_ram),
    .sp_o   (sp_o)
  );

  // stack borrows the indirect port
  always_comb begin
    if (stk_ram.en) port_b = stk_ram;
    else begin
      port_b.en    = ind_req_i;
      port_b.we    = ind_we_i;
      port_b.addr  = ind_addr_i;
      port_b.wdata = ind_wdata_i;
    end
  end

  idr_ram u_ram (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .a_i      (dir_ram),
    .b_i      (port_b),
    .a_rdata_o(ram_a_rdata),
    .b_rdata_o(ram_b_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    dir_sfr_rd_q <= 1'b0;
    else if (dir_req_i && !dir_we_i) dir_sfr_rd_q <= dir_addr_i[ADDR_W-1];
  end

  assign dir_rdata_o = dir_sfr_rd_q ? sfr_rdata_i : ram_a_rdata;
  assign ind_rdata_o = ram_b_rdata;
  assign stk_rdata_o = ram_b_rdata;
endmodule

// File: rtl/idr_checker.sv
module idr_checker
  import idr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dir_req_i,
  input logic [ADDR_W-1:0] dir_addr_i,
  input logic [BANK_W-1:0] bank_sel_i,
  input logic [RIDX_W-1:0] reg_idx_i,
  input logic [ADDR_W-1:0] reg_addr_o,
  input logic              push_i,
  input logic              pop_i,
  input logic [ADDR_W-1:0] sp_o,
  input logic              sfr_req_o,
  input logic [SFR_AW-1:0] sfr_addr_o
);
  AST_SFR_ONLY_DIRECT_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sfr_req_o |-> (dir_req_i && dir_addr_i[ADDR_W-1] && sfr_addr_o == dir_addr_i[SFR_AW-1:0])); // R3
  AST_SFR_NOT_LOWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_req_i && !dir_addr_i[ADDR_W-1]) |-> !sfr_req_o); // R3
  AST_REG_BANK_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_addr_o == ADDR_W'(bank_sel_i) * 8 + ADDR_W'(reg_idx_i)); // R5
  AST_PUSH_PREINC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> sp_o == $past(sp_o) + 8'd1); // R7
  AST_POP_POSTDEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> sp_o == $past(sp_o) - 8'd1); // R8
  AST_SP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pop_i && !push_i) |=> $stable(sp_o)); // R10
endmodule

bind idata_router idr_checker u_idr_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dir_req_i  (dir_req_i),
  .dir_addr_i (dir_addr_i),
  .bank_sel_i (bank_sel_i),
  .reg_idx_i  (reg_idx_i),
  .reg_addr_o (reg_addr_o),
  .push_i     (push_i),
  .pop_i      (pop_i),
  .sp_o       (sp_o),
  .sfr_req_o  (sfr_req_o),
  .sfr_addr_o (sfr_addr_o)
);

// File: tb/tb_idata_router.sv
`timescale 1ns/1ps
module tb_idata_router;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic dir_req, dir_we, ind_req, ind_we, push, pop;
  logic [7:0] dir_addr, dir_wdata, ind_addr, ind_wdata, stk_wdata;
  logic [7:0] dir_rdata, ind_rdata, stk_rdata, reg_addr, sp, sfr_wdata, sfr_rdata;
  logic [1:0] bank_sel;
  logic [2:0] reg_idx;
  logic sfr_req, sfr_we;
  logic [6:0] sfr_addr;
  int n_chk = 0, n_bad = 0;
  logic [7:0] sfr_model [128];

  always #10 clk = ~clk;

  idata_router dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .dir_req_i(dir_req), .dir_we_i(dir_we), .dir_addr_i(dir_addr), .dir_wdata_i(dir_wdata), .dir_rdata_o(dir_rdata),
    .ind_req_i(ind_req), .ind_we_i(ind_we), .ind_addr_i(ind_addr), .ind_wdata_i(ind_wdata), .ind_rdata_o(ind_rdata),
    .bank_sel_i(bank_sel), .reg_idx_i(reg_idx), .reg_addr_o(reg_addr),
    .push_i(push), .pop_i(pop), .stk_wdata_i(stk_wdata), .stk_rdata_o(stk_rdata), .sp_o(sp),
    .sfr_req_o(sfr_req), .sfr_we_o(sfr_we), .sfr_addr_o(sfr_addr), .sfr_wdata_o(sfr_wdata), .sfr_rdata_i(sfr_rdata)
  );

  // peripheral model: one-cycle read
  always_ff @(posedge clk) begin
    if (sfr_req && sfr_we)  sfr_model[sfr_addr] <= sfr_wdata;
    if (sfr_req && !sfr_we) sfr_rdata <= sfr_model[sfr_addr];
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    dir_req = 0; dir_we = 0; ind_req = 0; ind_we = 0; push = 0; pop = 0;
  endtask

  // one access; read result sampled a cycle later (R4)
  task automatic access(bit ind, bit we, logic [7:0] addr, logic [7:0] data, string req);
    @(negedge clk);
    idle();
    if (ind) begin ind_req = 1; ind_we = we; ind_addr = addr; ind_wdata = data; end
    else begin dir_req = 1; dir_we = we; dir_addr = addr; dir_wdata = data; end
    #1;
    if (!ind) begin
      check({req, " strobe"}, {7'd0, sfr_req}, {7'd0, addr[7]});
      if (addr[7]) check({req, " sfr addr"}, {1'b0, sfr_addr}, {1'b0, addr[6:0]});
    end
    @(negedge clk);
    idle();
    if (!we) check({req, "/R4 read"}, ind ? ind_rdata : dir_rdata, data);
  endtask

  // {ind, we, addr, data}: data is write value or expected read value
  localparam logic [17:0] VEC [16] = '{
    {1'b0, 1'b1, 8'h10, 8'hA5}, {1'b1, 1'b0, 8'h10, 8'hA5},
    {1'b1, 1'b1, 8'h90, 8'h3C}, {1'b1, 1'b0, 8'h90, 8'h3C},
    {1'b0, 1'b1, 8'h90, 8'h77}, {1'b1, 1'b0, 8'h90, 8'h3C},
    {1'b0, 1'b0, 8'h90, 8'h77}, {1'b1, 1'b1, 8'h7F, 8'h11},
    {1'b0, 1'b0, 8'h7F, 8'h11}, {1'b0, 1'b1, 8'h00, 8'hFE},
    {1'b1, 1'b0, 8'h00, 8'hFE}, {1'b1, 1'b1, 8'hFF, 8'h42},
    {1'b1, 1'b0, 8'hFF, 8'h42}, {1'b0, 1'b1, 8'hFF, 8'h99},
    {1'b0, 1'b0, 8'hFF, 8'h99}, {1'b1, 1'b0, 8'hFF, 8'h42}
  };

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle();
    dir_addr = 0; dir_wdata = 0; ind_addr = 0; ind_wdata = 0; stk_wdata = 0;
    bank_sel = 0; reg_idx = 0;
    repeat (3) @(negedge clk);
    check("R6 sp reset", sp, 8'h07);
    check("R3 no strobe at reset", {7'd0, sfr_req}, 8'h00);
    rst_ni = 1;

    for (int i = 0; i < 16; i++) begin
      logic [17:0] v;
      string tag;
      v = VEC[i];
      tag = v[15:8] < 8'h80 ? "R1" : (v[17] ? "R2" : "R3");
      access(v[17], v[16], v[15:8], v[7:0], tag);
    end

    // R5 bank mapping
    bank_sel = 2'd2; reg_idx = 3'd5; #1; check("R5 bank2 r5", reg_addr, 8'h15);
    bank_sel = 2'd3; reg_idx = 3'd7; #1; check("R5 bank3 r7", reg_addr, 8'h1F);
    bank_sel = 2'd0; reg_idx = 3'd0; #1; check("R5 bank0 r0", reg_addr, 8'h00);

    // R7 push
    @(negedge clk); idle(); push = 1; stk_wdata = 8'hC1;
    @(negedge clk); idle(); check("R7 sp after push", sp, 8'h08);
    access(1, 0, 8'h08, 8'hC1, "R7");
    @(negedge clk); idle(); push = 1; stk_wdata = 8'hC2;
    // R8 pop
    @(negedge clk); idle(); pop = 1;
    @(negedge clk); idle();
    check("R8 popped data", stk_rdata, 8'hC2);
    check("R8 sp after pop", sp, 8'h08);

    // R10 push and pop together
    @(negedge clk); idle(); push = 1; pop = 1; stk_wdata = 8'hD0;
    @(negedge clk); idle(); check("R10 sp", sp, 8'h09);
    access(1, 0, 8'h09, 8'hD0, "R10");

    // R11 push steals indirect port
    access(0, 1, 8'h30, 8'h00, "R11 setup");
    @(negedge clk); idle(); push = 1; stk_wdata = 8'hE0;
    ind_req = 1; ind_we = 1; ind_addr = 8'h30; ind_wdata = 8'h55;
    @(negedge clk); idle();
    access(0, 0, 8'h30, 8'h00, "R11 dropped write");
    access(1, 0, 8'h0A, 8'hE0, "R11 pushed byte");

    // R12 same-byte collision
    @(negedge clk); idle();
    dir_req = 1; dir_we = 1; dir_addr = 8'h40; dir_wdata = 8'h12;
    ind_req = 1; ind_we = 1; ind_addr = 8'h40; ind_wdata = 8'h34;
    @(negedge clk); idle();
    access(0, 0, 8'h40, 8'h34, "R12");

    // R9 wrap: sp 0x0A -> 0xFF after 11 pops
    for (int k = 0; k < 11; k++) begin
      @(negedge clk); idle(); pop = 1;
    end
    @(negedge clk); idle(); check("R9 wrap down", sp, 8'hFF);
    push = 1; stk_wdata = 8'hAB;
    @(negedge clk); idle(); check("R9 wrap up", sp, 8'h00);
    access(1, 0, 8'h00, 8'hAB, "R9 wrapped push");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule